// File: doc/BRIEF.md
# Two-Level Multi-CPU Interrupt Controller

This block collects level-sensitive interrupt sources and delivers each one to up to four CPUs. A source has to pass two gates before a CPU sees it. The first gate is a single global enable for the source. The second is an unmask bit that each CPU holds for that source. A CPU's request line is high while at least one source is pending, enabled and unmasked for that CPU. Sources 0 through 28 are private to each CPU. Sources above 28 are shared. For a shared source, the per-CPU unmask bits also serve as its routing field.

Software reaches the block through a simple register bus. The bus has two windows: a global one, and a per-CPU one. In the per-CPU window, a CPU number on the bus sideband selects which CPU's registers are touched. Enables and masks are not written as bitmaps. Software writes a source number to a set strobe or a clear strobe. A CPU reads its acknowledge register to learn which source to service. The value it gets back is the lowest-numbered source that is deliverable to it. Sources 0 and 1 are not taken from the wired inputs. They come from two summary inputs per CPU, one for inter-processor doorbells and one for message-signalled doorbells.

Top module: `icu_two_level`

## Requirements
- R1: After reset, all global enables are clear, every CPU masks every source, and every routing field reads 0. As a result, irq_o is 0 and every acknowledge read returns 1023.
- R2: A read of global offset 0x000 returns NUM_SRC in bits [11:2]. All other bits of the read are 0.
- R3: A write to global offset 0x030 sets the global enable of the source whose number is in wdata_i[9:0]. A write to global offset 0x034 clears that enable. A source whose enable is clear reaches no CPU.
- R4: A write to per-CPU offset 0x048 masks the source numbered in wdata_i[9:0]. A write to per-CPU offset 0x04C unmasks it. Both writes act only for the CPU given on cpu_id_i.
- R5: The control word of source n sits at global offset 0x100 + 4*n. For a shared source (n > 28), bit c of the word is the unmask bit for CPU c. It can be written and read back, and the mask and unmask strobes change the same bit. For a private source (n <= 28), a control-word write is ignored and the word reads 0.
- R6: irq_o[c] is high if and only if at least one source is pending, globally enabled and unmasked for CPU c.
- R7: Source 0 is pending for CPU c when ipi_db_i[c] is high. Source 1 is pending for CPU c when msi_db_i[c] is high. src_i[0] and src_i[1] are ignored.
- R8: A read of per-CPU offset 0x044 returns, in bits [9:0], the lowest-numbered source that is deliverable to the reading CPU, or 1023 if there is none. The read has no side effect: the source stays pending until its input drops.
- R9: Read data appears on rdata_o in the cycle after the request. A register write takes effect on the output from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| win_i | input | 1 | 0 = global window, 1 = per-CPU window |
| addr_i | input | ADDR_W | Byte offset within the window |
| wdata_i | input | 32 | Write data |
| cpu_id_i | input | CPU_W | CPU making the access (selects the per-CPU registers) |
| rdata_o | output | 32 | Read data, registered |
| src_i | input | NUM_SRC | Level-sensitive source inputs (bits 0 and 1 unused) |
| ipi_db_i | input | NUM_CPUS | Inter-processor doorbell summary, one bit per CPU |
| msi_db_i | input | NUM_CPUS | Message-signalled doorbell summary, one bit per CPU |
| irq_o | output | NUM_CPUS | Interrupt request, one per CPU |

## Verification
The main stimulus is a sweep over every wired source and every CPU. In each step, exactly one source is enabled, unmasked for exactly one CPU, and raised. That pattern separates a wrong source index, an unmask that leaks to another CPU, and a gate that is ignored, because each of these faults shows up as a wrong request bit or a wrong acknowledge value on one of the four CPUs.

Separate directed patterns cover three further cases:
- Two shared sources are pending together on one CPU. This checks the lowest-number ordering, and checks that the higher source appears once the lower one drops.
- Doorbell summaries are driven on some CPUs while the matching wired bits are also driven. This shows that the summaries, not src_i, feed sources 0 and 1.
- Control-word writes are made to private and to shared sources. This shows that routing applies only to shared sources, and that it shares its storage with the per-CPU mask strobes.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] NONE_ID = 10'd1023;

  localparam logic [11:0] OFF_CTRL   = 12'h000;
  localparam logic [11:0] OFF_EN_SET = 12'h030;
  localparam logic [11:0] OFF_EN_CLR = 12'h034;
  localparam logic [11:0] OFF_ROUTE  = 12'h100;
  localparam logic [11:0] OFF_ACK    = 12'h044;
  localparam logic [11:0] OFF_MASK   = 12'h048;
  localparam logic [11:0] OFF_UNMASK = 12'h04C;

  typedef enum logic {WIN_GLOBAL = 1'b0, WIN_CPU = 1'b1} win_e;
endpackage

// File: rtl/icu_gate_array.sv
module icu_gate_array #(
  parameter int NUM_CPUS  = 4,
  parameter int NUM_SRC   = 40,
  parameter int PRIV_LAST = 28,
  parameter int ADDR_W    = 12,
  parameter int CPU_W     = 2
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               en_set_i,
  input  logic                               en_clr_i,
  input  logic                               msk_set_i,
  input  logic                               msk_clr_i,
  input  logic [icu_pkg::ID_W-1:0]           num_i,
  input  logic [CPU_W-1:0]                   cpu_i,
  input  logic                               route_we_i,
  input  logic [ADDR_W-1:0]                  route_sel_i,
  input  logic [NUM_CPUS-1:0]                route_i,
  output logic [NUM_SRC-1:0]                 en_o,
  output logic [NUM_CPUS-1:0][NUM_SRC-1:0]   unmask_o
);
  import icu_pkg::*;

  for (genvar n = 0; n < NUM_SRC; n++) begin : g_src
    localparam logic [ID_W-1:0]   NUM_ID = ID_W'(n);
    localparam logic [ADDR_W-1:0] NUM_AD = ADDR_W'(n);
    localparam bit SHARED = (n > PRIV_LAST);
    logic hit;
    assign hit = (num_i == NUM_ID);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  en_o[n] <= 1'b0;
      else if (en_set_i && hit)     en_o[n] <= 1'b1;
      else if (en_clr_i && hit)     en_o[n] <= 1'b0;
    end

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
      logic own;
      assign own = hit && (cpu_i == CPU_W'(c));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                        unmask_o[c][n] <= 1'b0;
        else if (msk_set_i && own)                          unmask_o[c][n] <= 1'b0;
        else if (msk_clr_i && own)                          unmask_o[c][n] <= 1'b1;
        else if (SHARED && route_we_i && route_sel_i == NUM_AD) unmask_o[c][n] <= route_i[c];
      end
    end
  end
endmodule

// File: rtl/icu_pick.sv
module icu_pick #(
  parameter int NUM_SRC = 40
) (
  input  logic [NUM_SRC-1:0]        vec_i,
  output logic                      found_o,
  output logic [icu_pkg::ID_W-1:0]  id_o
);
  import icu_pkg::*;

  // Scan downward so the lowest set index is written last
  always_comb begin
    found_o = 1'b0;
    id_o    = NONE_ID;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        id_o    = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/icu_two_level.sv
module icu_two_level #(
  parameter int NUM_CPUS  = 4,
  parameter int NUM_SRC   = 40,
  parameter int PRIV_LAST = 28,
  parameter int ADDR_W    = 12,
  localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic                win_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  input  logic [CPU_W-1:0]    cpu_id_i,
  output logic [31:0]         rdata_o,
  input  logic [NUM_SRC-1:0]  src_i,
  input  logic [NUM_CPUS-1:0] ipi_db_i,
  input  logic [NUM_CPUS-1:0] msi_db_i,
  output logic [NUM_CPUS-1:0] irq_o
);
  import icu_pkg::*;

  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_EN_SET = ADDR_W'(OFF_EN_SET);
  localparam logic [ADDR_W-1:0] A_EN_CLR = ADDR_W'(OFF_EN_CLR);
  localparam logic [ADDR_W-1:0] A_ROUTE  = ADDR_W'(OFF_ROUTE);
  localparam logic [ADDR_W-1:0] A_ACK    = ADDR_W'(OFF_ACK);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFF_MASK);
  localparam logic [ADDR_W-1:0] A_UNMASK = ADDR_W'(OFF_UNMASK);
  localparam logic [31:0] CTRL_VAL = 32'(NUM_SRC) << 2;

  logic g_wr, p_wr, rd;
  logic route_hit;
  logic [ADDR_W-1:0] route_sel;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_CPUS-1:0][NUM_SRC-1:0] unmask_q;
  logic [NUM_CPUS-1:0][NUM_SRC-1:0] deliv;
  logic [NUM_CPUS-1:0][ID_W-1:0] ack_id;
  logic [NUM_CPUS-1:0] route_rd;
  logic [31:0] rd_val;

  assign g_wr = req_i && we_i && (win_i == WIN_GLOBAL);
  assign p_wr = req_i && we_i && (win_i == WIN_CPU);
  assign rd   = req_i && !we_i;
  assign route_hit = (addr_i >= A_ROUTE) && (addr_i[1:0] == 2'b00);
  assign route_sel = (addr_i - A_ROUTE) >> 2;

  icu_gate_array #(
    .NUM_CPUS(NUM_CPUS), .NUM_SRC(NUM_SRC), .PRIV_LAST(PRIV_LAST),
    .ADDR_W(ADDR_W), .CPU_W(CPU_W)
  ) i_gates (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_set_i   (g_wr && addr_i == A_EN_SET),
    .en_clr_i   (g_wr && addr_i == A_EN_CLR),
    .msk_set_i  (p_wr && addr_i == A_MASK),
    .msk_clr_i  (p_wr && addr_i == A_UNMASK),
    .num_i      (wdata_i[ID_W-1:0]),
    .cpu_i      (cpu_id_i),
    .route_we_i (g_wr && route_hit),
    .route_sel_i(route_sel),
    .route_i    (wdata_i[NUM_CPUS-1:0]),
    .en_o       (en_q),
    .unmask_o   (unmask_q)
  );

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic [NUM_SRC-1:0] pend;
    always_comb begin
      pend    = src_i;
      pend[0] = ipi_db_i[c];
      pend[1] = msi_db_i[c];
    end
    assign deliv[c] = pend & en_q & unmask_q[c];

    icu_pick #(.NUM_SRC(NUM_SRC)) i_pick (
      .vec_i  (deliv[c]),
      .found_o(irq_o[c]),
      .id_o   (ack_id[c])
    );
  end

  always_comb begin
    route_rd = '0;
    for (int n = PRIV_LAST + 1; n < NUM_SRC; n++) begin
      if (route_sel == ADDR_W'(n)) begin
        for (int c = 0; c < NUM_CPUS; c++) route_rd[c] = unmask_q[c][n];
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (win_i == WIN_GLOBAL) begin
      if (addr_i == A_CTRL)  rd_val = CTRL_VAL;
      else if (route_hit)    rd_val[NUM_CPUS-1:0] = route_rd;
    end else if (addr_i == A_ACK) begin
      rd_val[ID_W-1:0] = NONE_ID;
      for (int c = 0; c < NUM_CPUS; c++)
        if (cpu_id_i == CPU_W'(c)) rd_val[ID_W-1:0] = ack_id[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_val;
  end
endmodule

// File: rtl/icu_checker.sv
module icu_checker #(
  parameter int NUM_CPUS = 4,
  parameter int NUM_SRC  = 40,
  parameter int ADDR_W   = 12,
  parameter int CPU_W    = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic                win_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [31:0]         wdata_i,
  input logic [CPU_W-1:0]    cpu_id_i,
  input logic [31:0]         rdata_o,
  input logic [NUM_SRC-1:0]  src_i,
  input logic [NUM_CPUS-1:0] ipi_db_i,
  input logic [NUM_CPUS-1:0] msi_db_i,
  input logic [NUM_CPUS-1:0] irq_o,
  input logic [NUM_SRC-1:0]  en_q
);
  localparam int SEL_W = $clog2(NUM_SRC);

  logic ack_rd, ctrl_rd, en_set_wr, en_clr_wr, num_ok;
  assign ack_rd    = req_i && !we_i && win_i && addr_i == ADDR_W'(12'h044);
  assign ctrl_rd   = req_i && !we_i && !win_i && addr_i == '0;
  assign en_set_wr = req_i && we_i && !win_i && addr_i == ADDR_W'(12'h030);
  assign en_clr_wr = req_i && we_i && !win_i && addr_i == ADDR_W'(12'h034);
  assign num_ok    = wdata_i[9:0] < 10'(NUM_SRC);

  assert_ctrl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rd |=> rdata_o == (32'(NUM_SRC) << 2));

  assert_en_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_set_wr && num_ok) |=> en_q[$past(wdata_i[SEL_W-1:0])]);

  assert_en_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_clr_wr && num_ok) |=> !en_q[$past(wdata_i[SEL_W-1:0])]);

  assert_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_i == '0 && ipi_db_i == '0 && msi_db_i == '0) |-> irq_o == '0);

  assert_no_irq_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rd && !irq_o[cpu_id_i] && $stable(en_q)) |=> rdata_o[9:0] == 10'd1023);

  assert_irq_ack_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rd && irq_o[cpu_id_i]) |=> rdata_o[9:0] < 10'(NUM_SRC));
endmodule

bind icu_two_level icu_checker #(
  .NUM_CPUS(NUM_CPUS), .NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .CPU_W(CPU_W)
) i_icu_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .win_i(win_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .cpu_id_i(cpu_id_i), .rdata_o(rdata_o),
  .src_i(src_i), .ipi_db_i(ipi_db_i), .msi_db_i(msi_db_i), .irq_o(irq_o),
  .en_q(en_q)
);

// File: tb/test_icu_two_level.sv
module test_icu_two_level;
  localparam int NC = 4;
  localparam int NS = 40;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req = 0, we = 0, win = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [1:0] cpu_id = '0;
  logic [NS-1:0] src = '0;
  logic [NC-1:0] ipi = '0, msi = '0, irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  icu_two_level i_icu_two_level (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .win_i(win),
    .addr_i(addr), .wdata_i(wdata), .cpu_id_i(cpu_id), .rdata_o(rdata),
    .src_i(src), .ipi_db_i(ipi), .msi_db_i(msi), .irq_o(irq)
  );

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic wr(logic w, logic [11:0] a, logic [31:0] d, logic [1:0] c);
    @(negedge clk);
    req = 1; we = 1; win = w; addr = a; wdata = d; cpu_id = c;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(logic w, logic [11:0] a, logic [1:0] c, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; win = w; addr = a; cpu_id = c;
    @(negedge clk);
    req = 0;
    d = rdata;
  endtask

  task automatic ack(logic [1:0] c, logic [31:0] exp, string r);
    logic [31:0] d;
    rd(1'b1, 12'h044, c, d);
    chk(r, {22'd0, d[9:0]}, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1 reset state
    @(negedge clk);
    chk("R1 irq", 32'(irq), 0);
    for (int c = 0; c < NC; c++) ack(2'(c), 1023, "R1 ack");
    rd(1'b0, 12'h178, 0, d); chk("R1 route", d, 0);
    // R2
    rd(1'b0, 12'h000, 0, d); chk("R2 ctrl", d, NS << 2);

    // Sweep: R3 R4 R6 R8 for every wired source on every CPU
    for (int n = 2; n < NS; n++) begin
      for (int c = 0; c < NC; c++) begin
        wr(1'b0, 12'h030, n, 0);
        wr(1'b1, 12'h04C, n, 2'(c));
        src = '0; src[n] = 1'b1;
        @(negedge clk);
        chk("R4 R6 irq", 32'(irq), 32'(1 << c));
        for (int k = 0; k < NC; k++) ack(2'(k), (k == c) ? n : 1023, "R4 R8 ack");
        wr(1'b0, 12'h034, n, 0);
        @(negedge clk);
        chk("R3 disabled", 32'(irq), 0);
        wr(1'b1, 12'h048, n, 2'(c));
        src = '0;
      end
    end

    // R5 routing of shared source 30
    wr(1'b0, 12'h030, 30, 0);
    src = '0; src[30] = 1;
    wr(1'b0, 12'h178, 32'h4, 0);
    @(negedge clk);
    chk("R5 route irq", 32'(irq), 4);
    rd(1'b0, 12'h178, 0, d); chk("R5 route read", d, 4);
    wr(1'b1, 12'h048, 30, 2);
    @(negedge clk);
    chk("R5 mask clears route irq", 32'(irq), 0);
    rd(1'b0, 12'h178, 0, d); chk("R5 mask clears route read", d, 0);
    wr(1'b1, 12'h04C, 30, 1);
    rd(1'b0, 12'h178, 0, d); chk("R5 unmask sets route", d, 2);
    wr(1'b0, 12'h034, 30, 0);
    wr(1'b0, 12'h178, 0, 0);
    src = '0;
    // R5 private source 5 ignores routing
    wr(1'b0, 12'h030, 5, 0);
    src[5] = 1;
    wr(1'b0, 12'h114, 32'hF, 0);
    @(negedge clk);
    chk("R5 private route ignored", 32'(irq), 0);
    rd(1'b0, 12'h114, 0, d); chk("R5 private reads zero", d, 0);
    wr(1'b0, 12'h034, 5, 0);
    src = '0;

    // R7 doorbell summaries
    wr(1'b0, 12'h030, 0, 0);
    wr(1'b0, 12'h030, 1, 0);
    wr(1'b1, 12'h04C, 0, 3);
    wr(1'b1, 12'h04C, 1, 0);
    src[0] = 1; src[1] = 1;
    @(negedge clk);
    chk("R7 src bits 0 1 ignored", 32'(irq), 0);
    ipi = 4'b1100;
    @(negedge clk);
    chk("R7 ipi irq", 32'(irq), 8);
    ack(3, 0, "R7 ipi ack");
    ack(2, 1023, "R7 ipi masked cpu");
    msi = 4'b0001;
    @(negedge clk);
    chk("R7 msi irq", 32'(irq), 9);
    ack(0, 1, "R7 msi ack");
    ipi = '0; msi = '0; src = '0;

    // R8 lowest-number order, no side effect
    wr(1'b0, 12'h030, 30, 0);
    wr(1'b0, 12'h030, 35, 0);
    wr(1'b0, 12'h178, 2, 0);
    wr(1'b0, 12'h18C, 2, 0);
    src[30] = 1; src[35] = 1;
    @(negedge clk);
    ack(1, 30, "R8 lowest");
    ack(1, 30, "R8 read no side effect");
    src[30] = 0;
    @(negedge clk);
    ack(1, 35, "R8 next after drop");
    // R9 read data latency
    @(negedge clk);
    req = 1; we = 0; win = 0; addr = 12'h000;
    chk("R9 not before edge", rdata[9:0], 35);
    @(negedge clk);
    req = 0;
    chk("R9 after edge", rdata, NS << 2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule